// File: doc/BRIEF.md
# Adaptive Motion Smoothing Filter

This block takes a stream of raw per-frame camera motion values, one signed word per frame, such as a horizontal shift or one coefficient of an affine model. It splits each value into the part the operator meant and the part that is shake. The smoothed output is a low-pass filtered copy of the input and is taken as intended motion. The correction output is raw minus smoothed, which is the shake a later warping stage must undo.

The filter is fourth order. It is built as two second-order sections in series, and every coefficient is a signed fixed-point number with 14 fractional bits. Eight coefficient sets are held in a small table that a host writes. For each sample, the set is chosen by the size of that sample. A host programs the high-index sets with fast, light filters and the low-index sets with heavy smoothing, so large deliberate pans are followed quickly and small jitter is strongly damped. A single multiply-accumulate unit computes the ten taps one after another, which suits the low rate of one sample per frame.

Samples enter on a valid/ready stream and results leave on a valid/ready stream. Back-pressure rules are as follows. `in_ready` is high only when no sample is being computed and no result is waiting. A result stays on the output, unchanged, until `out_ready` is seen high. Only then is a new sample accepted. A synchronous clear empties the filter history.

Top module: `motion_smoother`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. Every coefficient set is the identity filter (tap 0 and tap 5 equal 16384, all other taps 0), so a sample comes out unchanged with a correction of 0.
- R2: A sample is accepted on a clock where `in_valid` and `in_ready` are both high. `in_ready` is low from the next clock until the result for that sample has been taken. `in_ready` and `out_valid` are never high together.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_smooth` and `out_corr` hold their values.
- R4: Each section computes y = b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2]. Taps 0..4 are b0, b1, b2, a1, a2 of the first section, and taps 5..9 are the same for the second section, whose input is the first section's output. Each section result is (sum + 8192) arithmetically shifted right by 14. History carries from one sample to the next.
- R5: Each section result is saturated to the range −32768..32767 instead of wrapping.
- R6: `out_corr` equals the accepted input minus `out_smooth`, saturated to −32768..32767.
- R7: The coefficient set used for a sample has index min(|x|, 32767) >> 12, so −32768 uses set 7.
- R8: A write with `cfg_we` high stores `cfg_val` into tap `cfg_tap` of set `cfg_set`. A sample uses the coefficients present when it was accepted, and a write during its computation first affects the next accepted sample.
- R9: A write to a tap number of 10 or above changes no coefficient.
- R10: `clr` zeroes the history of both sections, drops any sample in flight and any pending result (`out_valid` is 0 on the next clock), and keeps the coefficient table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of filter history and work in flight |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_set | input | 3 | Coefficient set to write |
| cfg_tap | input | 4 | Tap number to write (0..9) |
| cfg_val | input | 16 | Signed coefficient, 14 fractional bits |
| in_valid | input | 1 | Raw sample valid |
| in_ready | output | 1 | Block can accept a raw sample |
| in_data | input | 16 | Signed raw motion sample |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_smooth | output | 16 | Smoothed (intended) motion |
| out_corr | output | 16 | Shake correction, raw minus smoothed |

## Verification
The bench targets magnitude boundaries of the set selection: 4095 against 4096, 28671 against 28672, and −32768. A design with a wrong index would run these samples through the wrong filter, and the output would come out halved or unhalved. It drives section results far past full scale in both directions, plus a correction that overflows. Wrapping arithmetic there would flip the sign of the output. It rewrites a coefficient while a sample is being computed, and checks that clearing mid-sample leaves no result behind. A design without a working coefficient copy would give a blend of old and new taps, and one that forgot to drop work would present a stale result. A long back-pressure stall and a write to tap 12 check that held outputs do not move and that the stray write does not alias onto a real tap.

// File: rtl/msf_pkg.sv
package msf_pkg;
  localparam int unsigned TAPS_PER_SEC = 5;
  localparam int unsigned NUM_SEC      = 2;
  localparam int unsigned NUM_TAPS     = TAPS_PER_SEC * NUM_SEC;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_OUT  = 2'd2
  } msf_state_e;

  // feedback taps (a1, a2) are subtracted
  function automatic logic tap_is_feedback(input int unsigned t);
    return (t % TAPS_PER_SEC) >= 3;
  endfunction
endpackage

// File: rtl/msf_coef_bank.sv
module msf_coef_bank #(
  parameter int unsigned SETS   = 8,
  parameter int unsigned NTAPS  = 10,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC   = 14
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(SETS)-1:0]       wr_set,
  input  logic [$clog2(NTAPS)-1:0]      wr_tap,
  input  logic signed [COEF_W-1:0]      wr_val,
  input  logic [$clog2(SETS)-1:0]       rd_set,
  output logic [NTAPS*COEF_W-1:0]       rd_coefs
);
  localparam int unsigned TAP_W = $clog2(NTAPS);
  localparam int unsigned SEC_TAPS = msf_pkg::TAPS_PER_SEC;
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(1 << FRAC);

  logic signed [COEF_W-1:0] mem [SETS][NTAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(SETS); s++)
        for (int t = 0; t < int'(NTAPS); t++)
          mem[s][t] <= ((t % int'(SEC_TAPS)) == 0) ? UNITY : '0;
    end else if (wr_en && (wr_tap < TAP_W'(NTAPS))) begin
      mem[wr_set][wr_tap] <= wr_val;
    end
  end

  for (genvar t = 0; t < int'(NTAPS); t++) begin : g_rd
    assign rd_coefs[t*COEF_W +: COEF_W] = mem[rd_set][t];
  end
endmodule

// File: rtl/msf_mag_index.sv
module msf_mag_index #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned SETS   = 8
) (
  input  logic signed [DATA_W-1:0]  sample,
  output logic [$clog2(SETS)-1:0]   set_idx
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam logic [DATA_W-1:0] MAG_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] mag;

  always_comb begin
    if (sample == NEG_MIN)      mag = MAG_MAX;
    else if (sample[DATA_W-1])  mag = DATA_W'(-sample);
    else                        mag = sample;
    set_idx = SET_W'(mag >> (DATA_W - 1 - SET_W));
  end
endmodule

// File: rtl/msf_mac_unit.sv
module msf_mac_unit #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC   = 14,
  parameter int unsigned ACC_W  = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     start,
  input  logic                     neg,
  input  logic signed [COEF_W-1:0] coef,
  input  logic signed [DATA_W-1:0] opnd,
  output logic signed [DATA_W-1:0] res
);
  localparam int unsigned PW = COEF_W + DATA_W;
  localparam logic signed [ACC_W:0] ACC_HI = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] ACC_LO = {2'b11, {(ACC_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] RES_HI = {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] RES_LO = {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1 << (FRAC - 1));

  logic signed [ACC_W-1:0] acc_q;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W:0]   base, sum;
  logic signed [ACC_W-1:0] acc_d, rsum, shifted;

  always_comb begin
    prod  = PW'(coef) * PW'(opnd);
    base  = start ? '0 : (ACC_W+1)'(acc_q);
    sum   = neg ? base - (ACC_W+1)'(prod) : base + (ACC_W+1)'(prod);
    if (sum > ACC_HI)      acc_d = ACC_HI[ACC_W-1:0];
    else if (sum < ACC_LO) acc_d = ACC_LO[ACC_W-1:0];
    else                   acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  acc_q <= '0;
    else if (en) acc_q <= acc_d;
  end

  // round half up, then clip to the data range
  always_comb begin
    rsum    = acc_q + HALF;
    shifted = rsum >>> FRAC;
    if (shifted > RES_HI)      res = RES_HI[DATA_W-1:0];
    else if (shifted < RES_LO) res = RES_LO[DATA_W-1:0];
    else                       res = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/motion_smoother.sv
module motion_smoother #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned FRAC   = 14,
  parameter int unsigned SETS   = 8,
  parameter int unsigned ACC_W  = 40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         cfg_we,
  input  logic [$clog2(SETS)-1:0]      cfg_set,
  input  logic [3:0]                   cfg_tap,
  input  logic signed [COEF_W-1:0]     cfg_val,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic signed [DATA_W-1:0]     in_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic signed [DATA_W-1:0]     out_smooth,
  output logic signed [DATA_W-1:0]     out_corr
);
  import msf_pkg::*;

  localparam int unsigned NTAPS  = NUM_TAPS;
  localparam int unsigned SET_W  = $clog2(SETS);
  localparam int unsigned STEP_W = $clog2(NTAPS + 1);
  localparam int unsigned TAP_W  = $clog2(NTAPS);
  localparam logic [STEP_W-1:0] SEC2_STEP = STEP_W'(TAPS_PER_SEC);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NTAPS);
  localparam logic signed [DATA_W:0] D_HI = {2'b00, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W:0] D_LO = {2'b11, {(DATA_W-1){1'b0}}};

  msf_state_e               state;
  logic [STEP_W-1:0]        step;
  logic signed [DATA_W-1:0] x_q, sec1_y;
  logic signed [DATA_W-1:0] s1_x1, s1_x2, s1_y1, s1_y2, s2_y1, s2_y2;
  logic signed [COEF_W-1:0] wcoef [NTAPS];
  logic [NTAPS*COEF_W-1:0]  bank_rd;
  logic [SET_W-1:0]         sel_set;
  logic signed [DATA_W-1:0] mac_res, mac_opnd;
  logic signed [COEF_W-1:0] mac_coef;
  logic                     mac_en, mac_start, mac_neg;
  logic signed [DATA_W:0]   diff;
  logic signed [DATA_W-1:0] corr_sat;
  logic                     accept, finish;

  msf_mag_index #(.DATA_W(DATA_W), .SETS(SETS)) u_idx (
    .sample (in_data),
    .set_idx(sel_set)
  );

  msf_coef_bank #(.SETS(SETS), .NTAPS(NTAPS), .COEF_W(COEF_W), .FRAC(FRAC)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_set  (cfg_set),
    .wr_tap  (TAP_W'(cfg_tap)),
    .wr_val  (cfg_val),
    .rd_set  (sel_set),
    .rd_coefs(bank_rd)
  );

  msf_mac_unit #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FRAC(FRAC), .ACC_W(ACC_W)) u_mac (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (mac_en),
    .start(mac_start),
    .neg  (mac_neg),
    .coef (mac_coef),
    .opnd (mac_opnd),
    .res  (mac_res)
  );

  assign in_ready  = (state == ST_IDLE) && !clr;
  assign out_valid = (state == ST_OUT);
  assign accept    = in_valid && in_ready;
  assign finish    = (state == ST_RUN) && (step == LAST_STEP);

  // tap sequencing: section one on steps 0..4, section two on 5..9
  always_comb begin
    mac_en    = (state == ST_RUN) && (step < LAST_STEP) && !clr;
    mac_start = (step == '0) || (step == SEC2_STEP);
    mac_neg   = tap_is_feedback(int'(step));
    mac_coef  = (step < LAST_STEP) ? wcoef[TAP_W'(step)] : '0;
    case (step)
      4'd0:    mac_opnd = x_q;
      4'd1:    mac_opnd = s1_x1;
      4'd2:    mac_opnd = s1_x2;
      4'd3:    mac_opnd = s1_y1;
      4'd4:    mac_opnd = s1_y2;
      4'd5:    mac_opnd = mac_res;
      4'd6:    mac_opnd = s1_y1;
      4'd7:    mac_opnd = s1_y2;
      4'd8:    mac_opnd = s2_y1;
      4'd9:    mac_opnd = s2_y2;
      default: mac_opnd = '0;
    endcase
  end

  always_comb begin
    diff = (DATA_W+1)'(x_q) - (DATA_W+1)'(mac_res);
    if (diff > D_HI)      corr_sat = D_HI[DATA_W-1:0];
    else if (diff < D_LO) corr_sat = D_LO[DATA_W-1:0];
    else                  corr_sat = diff[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      step       <= '0;
      x_q        <= '0;
      sec1_y     <= '0;
      s1_x1      <= '0;
      s1_x2      <= '0;
      s1_y1      <= '0;
      s1_y2      <= '0;
      s2_y1      <= '0;
      s2_y2      <= '0;
      out_smooth <= '0;
      out_corr   <= '0;
      for (int t = 0; t < int'(NTAPS); t++) wcoef[t] <= '0;
    end else if (clr) begin
      state <= ST_IDLE;
      step  <= '0;
      s1_x1 <= '0;
      s1_x2 <= '0;
      s1_y1 <= '0;
      s1_y2 <= '0;
      s2_y1 <= '0;
      s2_y2 <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          x_q   <= in_data;
          step  <= '0;
          state <= ST_RUN;
          for (int t = 0; t < int'(NTAPS); t++)
            wcoef[t] <= bank_rd[t*COEF_W +: COEF_W];
        end
        ST_RUN: if (finish) begin
          out_smooth <= mac_res;
          out_corr   <= corr_sat;
          s1_x2      <= s1_x1;
          s1_x1      <= x_q;
          s1_y2      <= s1_y1;
          s1_y1      <= sec1_y;
          s2_y2      <= s2_y1;
          s2_y1      <= mac_res;
          state      <= ST_OUT;
        end else begin
          if (step == SEC2_STEP) sec1_y <= mac_res;
          step <= step + 1'b1;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/motion_smoother_chk.sv
module motion_smoother_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] out_smooth,
  input logic signed [DATA_W-1:0] out_corr
);
  localparam logic signed [DATA_W:0] C_HI = {2'b00, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W:0] C_LO = {2'b11, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] raw_q;
  logic signed [DATA_W:0]   delta;
  logic signed [DATA_W-1:0] want_corr;

  always_ff @(posedge clk) begin
    if (!rst_n)                     raw_q <= '0;
    else if (in_valid && in_ready)  raw_q <= in_data;
  end

  always_comb begin
    delta = (DATA_W+1)'(raw_q) - (DATA_W+1)'(out_smooth);
    if (delta > C_HI)      want_corr = C_HI[DATA_W-1:0];
    else if (delta < C_LO) want_corr = C_LO[DATA_W-1:0];
    else                   want_corr = delta[DATA_W-1:0];
  end

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_smooth) && $stable(out_corr)));

  assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_corr_relation_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_corr == want_corr));

  assert_clear_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);
endmodule

bind motion_smoother motion_smoother_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_smooth(out_smooth),
  .out_corr  (out_corr)
);

// File: tb/tb_motion_smoother.sv
module tb_motion_smoother;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_set = '0;
  logic [3:0] cfg_tap = '0;
  logic signed [15:0] cfg_val = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_smooth, out_corr;

  always #5 clk = ~clk;

  motion_smoother dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .cfg_we(cfg_we), .cfg_set(cfg_set), .cfg_tap(cfg_tap), .cfg_val(cfg_val),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_smooth(out_smooth), .out_corr(out_corr)
  );

  int ntests = 0;
  int nfail  = 0;

  // stateless half-gain vectors: {input, smoothed, correction}
  localparam int VEC [7][3] = '{
    '{100, 50, 50}, '{-7, -3, -4}, '{3, 2, 1}, '{-1, 0, -1},
    '{32767, 16384, 16383}, '{-32768, -16384, -16384}, '{0, 0, 0}
  };

  // reference model
  int mc [8][10];
  longint mx1, mx2, my1, my2, mz1, mz2;

  function automatic longint clip16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint rs(longint a);
    return clip16((a + 8192) >>> 14);
  endfunction

  function automatic int model(int x);
    int idx;
    longint y1, y2;
    idx = (x == -32768) ? 7 : (((x < 0) ? -x : x) >> 12);
    y1 = rs(mc[idx][0]*x + mc[idx][1]*mx1 + mc[idx][2]*mx2 - mc[idx][3]*my1 - mc[idx][4]*my2);
    y2 = rs(mc[idx][5]*y1 + mc[idx][6]*my1 + mc[idx][7]*my2 - mc[idx][8]*mz1 - mc[idx][9]*mz2);
    mx2 = mx1; mx1 = x; my2 = my1; my1 = y1; mz2 = mz1; mz1 = y2;
    return int'(y2);
  endfunction

  task automatic model_clear();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0; mz1 = 0; mz2 = 0;
  endtask

  task automatic check(string req, string what, int act, int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int s, int t, int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_set = 3'(s); cfg_tap = 4'(t); cfg_val = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    if (t < 10) mc[s][t] = v;
  endtask

  task automatic send(int x);
    @(negedge clk);
    in_data = 16'(x); in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(output int sm, output int co);
    while (!out_valid) @(negedge clk);
    sm = int'(out_smooth); co = int'(out_corr);
    @(negedge clk);
  endtask

  task automatic run(string req, int x, int exp_s, int exp_c);
    int sm, co;
    send(x);
    recv(sm, co);
    check(req, $sformatf("smooth for %0d", x), sm, exp_s);
    check(req, $sformatf("corr for %0d", x), co, exp_c);
  endtask

  task automatic run_model(string req, int x);
    int e;
    e = model(x);
    run(req, x, e, int'(clip16(longint'(x) - e)));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    int sm, co, hs, hc, e;
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 10; t++) mc[s][t] = (t == 0 || t == 5) ? 16384 : 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and identity default
    check("R1", "in_ready after reset", int'(in_ready), 1);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    run("R1", 1234, 1234, 0);
    run("R1", -5, -5, 0);

    // R7 set selection by magnitude: set 7 halves
    wr(7, 0, 8192);
    run("R7", 100, 100, 0);
    run("R7", 30000, 15000, 15000);
    run("R7", -32768, -16384, -16384);
    run("R7", 4095, 4095, 0);
    run("R7", 4096, 4096, 0);
    run("R7", 28671, 28671, 0);
    run("R7", 28672, 14336, 14336);

    // R4 R6 vector table with every set at half gain
    for (int s = 0; s < 7; s++) wr(s, 0, 8192);
    for (int i = 0; i < 7; i++)
      run("R4_R6", VEC[i][0], VEC[i][1], VEC[i][2]);

    // R5 saturation of section result and correction
    wr(7, 0, 32767);
    run("R5", 30000, 32767, -2767);
    run("R5", -30000, -32768, 2768);
    wr(7, 0, -16384);
    run("R5", 32767, -32767, 32767);

    // R9 write to a tap past the end changes nothing
    wr(7, 12, 5000);
    wr(7, 10, 9000);
    run("R9", 32767, -32767, 32767);

    // R4 recursive step response: y = 0.25x + 0.75y1 per section
    for (int s = 0; s < 8; s++) begin
      wr(s, 0, 4096); wr(s, 3, -12288); wr(s, 5, 4096); wr(s, 8, -12288);
    end
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    model_clear();
    for (int i = 0; i < 6; i++) run_model("R4", 1000);

    // R8 write during computation affects only the next sample
    e = model(2000);
    send(2000);
    wr(0, 0, 8192);
    recv(sm, co);
    check("R8", "in-flight sample uses old coefficients", sm, e);
    run_model("R8", 2000);

    // R10 clear in idle resets history, keeps table
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    model_clear();
    run_model("R10", 1000);
    run_model("R10", 1000);

    // R10 clear with a sample in flight drops it
    send(3000);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    model_clear();
    hs = 0;
    for (int i = 0; i < 16; i++) begin
      if (out_valid) hs = 1;
      @(negedge clk);
    end
    check("R10", "no result after mid-sample clear", hs, 0);
    run_model("R10", 500);

    // R3 R2 back-pressure holds the result
    out_ready = 1'b0;
    e = model(-1500);
    send(-1500);
    while (!out_valid) @(negedge clk);
    hs = int'(out_smooth); hc = int'(out_corr);
    check("R3", "smooth under stall", hs, e);
    hs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!out_valid || int'(out_smooth) != e || int'(out_corr) != hc) hs = 1;
      if (in_ready) hs = hs | 2;
    end
    check("R3", "output held during stall", hs & 1, 0);
    check("R2", "in_ready low while result pending", hs & 2, 0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R2", "result taken", int'(out_valid), 0);
    check("R2", "ready again after take", int'(in_ready), 1);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule